// File: doc/BRIEF.md
# Serial Video Retimer Control and Status Logic

This block is the control and status logic of a serial digital video retimer. It runs on the 27 MHz reference clock. The analog clock recovery loop and a rate detector are outside the block. They report a raw loop-lock flag and a detected-rate class. The block combines these reports with the board-level controls: the rate selection, a forced-bypass pin, an active-low output mute and the mode select of the second output. From them it produces a qualified lock indicator, a registered SD/HD indicator, the bypass enable for the retiming path, and the mute and mode controls for the two differential outputs.

A lock tracker decides when the retimer may be trusted. It requires the loop lock and an accepted rate class to hold unchanged for an acquisition window before lock asserts. Once locked, it drops lock after a loss window of continuous disagreement. The output stage applies a fixed priority. Mute wins over everything else. Forced bypass holds lock low. During any bypass the second output is muted when it carries the clock, and it stays live when it carries data. The board-level pins are asynchronous and pass through two-flop synchronizers before they are used.

Top module: `sdi_reclock_ctl`

## Requirements
- R1: While reset is held, lock_o=0, sd_o=0, retime_bypass_o=1, out1_mute_o=0, out2_mute_o=0 and out2_clk_sel_o=0. This corresponds to automatic rate, auto-bypass, outputs enabled and data mode on the second output.
- R2: rate_sel_i, force_bypass_i, mute_n_i and clk_out_sel_i pass through a two-flop synchronizer. A change driven before clock edge k is acted on at edge k+2. For example, out2_clk_sel_o and the mute outputs follow their pins two edges later.
- R3: The rate_sel_i code decides which detected rates are accepted. Codes 2'b00 and 2'b11 accept SD, HD and 3G. Code 2'b01 accepts SD only. Code 2'b10 accepts HD and 3G only. The det_rate_i code is 2'b00 for no supported rate, 2'b01 for SD (270 Mbps), 2'b10 for HD and 2'b11 for 3G.
- R4: While unlocked, lock_o rises at the edge where pll_lock_i has been high with an accepted and unchanged det_rate_i for ACQ_CYC consecutive edges.
- R5: While locked, lock_o falls at the edge that completes LOS_CYC consecutive edges on which pll_lock_i is low, the rate is not accepted, or det_rate_i differs from the rate held at lock. A shorter disturbance has no effect.
- R6: det_rate_i = 2'b00 never leads to lock, even with pll_lock_i high. This covers unsupported rates and harmonics.
- R7: While the synchronized force_bypass_i is high, lock_o is held low from the next edge. After release, acquisition starts from zero.
- R8: retime_bypass_o is high whenever the synchronized force_bypass_i is high or lock_o is low.
- R9: While the synchronized mute_n_i is low, out1_mute_o and out2_mute_o are both high, whatever the lock or bypass state.
- R10: When bypass is active and the second output is in clock mode, out2_mute_o is high. In data mode the second output follows the mute input only.
- R11: sd_o is high only when locked to SD. It is registered, so it changes one edge after each lock change and after the held rate changes. It is low whenever lock_o was low on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 27 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 2 | Rate selection code (asynchronous) |
| force_bypass_i | input | 1 | Forces the retimer into bypass when high (asynchronous) |
| mute_n_i | input | 1 | Mutes both outputs when low (asynchronous) |
| clk_out_sel_i | input | 1 | Second output carries clock when high, data when low (asynchronous) |
| pll_lock_i | input | 1 | Raw loop-lock flag from the clock recovery |
| det_rate_i | input | 2 | Detected rate class from the rate detector |
| lock_o | output | 1 | Qualified lock indicator |
| sd_o | output | 1 | Registered SD (high) / HD-3G (low) indicator |
| retime_bypass_o | output | 1 | Routes data around the retimer when high |
| out1_mute_o | output | 1 | Mute for the primary output (static, opposite legs) |
| out2_mute_o | output | 1 | Mute for the second output (static, opposite legs) |
| out2_clk_sel_o | output | 1 | Second output carries recovered clock when high |

## Verification
Forced bypass and the lock decision can land on the same edge. The bench raises the bypass pin while the loop is locked and in clock mode. It then judges the cycle in which the retimer is bypassed and the second output is muted while lock_o is still high, and the following edge on which lock_o and then sd_o fall. It also holds mute low together with bypass and with a fresh lock, so mute, the clock-mode bypass mute and lock all apply at once. The mute result must not depend on the other two. A behavioural reference model with queue-based synchronizers is compared with all six outputs on every clock.

// File: rtl/sdi_ctl_pkg.sv
package sdi_ctl_pkg;

    // detected rate classes reported by the rate detector
    localparam logic [1:0] DET_NONE = 2'b00;
    localparam logic [1:0] DET_SD   = 2'b01;
    localparam logic [1:0] DET_HD   = 2'b10;
    localparam logic [1:0] DET_3G   = 2'b11;

    // rate selection codes
    localparam logic [1:0] RSEL_AUTO = 2'b00;
    localparam logic [1:0] RSEL_SD   = 2'b01;
    localparam logic [1:0] RSEL_HD   = 2'b10;
    localparam logic [1:0] RSEL_TEST = 2'b11;

    // board-level controls after synchronization
    typedef struct packed {
        logic       mute_n;
        logic       force_byp;
        logic       clk_mode;
        logic [1:0] rsel;
    } ctl_sync_t;

    localparam ctl_sync_t CTL_RST = '{mute_n: 1'b1, force_byp: 1'b0,
                                      clk_mode: 1'b0, rsel: RSEL_AUTO};

    // whether a detected rate class is acceptable in the selected mode
    function automatic logic rate_ok(input logic [1:0] rsel, input logic [1:0] det);
        logic ok;
        case (rsel)
            RSEL_SD: ok = (det == DET_SD);
            RSEL_HD: ok = (det == DET_HD) || (det == DET_3G);
            default: ok = (det != DET_NONE);
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/sdi_sync2.sv
module sdi_sync2 #(
    parameter int             W       = 1,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = d_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{s1: RST_VAL, s2: RST_VAL};
        end else begin
            st_q <= st_d;
        end
    end

    assign q_o = st_q.s2;

endmodule

// File: rtl/sdi_lock_track.sv
module sdi_lock_track
    import sdi_ctl_pkg::*;
#(
    parameter int ACQ_CYC = 270000,
    parameter int LOS_CYC = 13500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rsel_i,
    input  logic       force_byp_i,
    input  logic       pll_lock_i,
    input  logic [1:0] det_rate_i,
    output logic       lock_o,
    output logic       sd_o
);

    localparam int CMAX = (ACQ_CYC > LOS_CYC) ? ACQ_CYC : LOS_CYC;
    localparam int CW   = $clog2(CMAX + 1);
    localparam logic [CW-1:0] ACQ_L = CW'(ACQ_CYC);
    localparam logic [CW-1:0] LOS_L = CW'(LOS_CYC);
    localparam logic [CW-1:0] ONE_L = CW'(1);

    typedef struct packed {
        logic          lock;
        logic          sd;
        logic [1:0]    rate;
        logic [CW-1:0] cnt;
    } trk_t;

    trk_t          st_d, st_q;
    logic          accept;
    logic          same_rate;
    logic [CW-1:0] cnt_inc;

    always_comb begin
        accept    = pll_lock_i && rate_ok(rsel_i, det_rate_i);
        same_rate = (det_rate_i == st_q.rate);
        cnt_inc   = st_q.cnt + ONE_L;

        st_d    = st_q;
        // indicator trails the lock state by one reference period
        st_d.sd = st_q.lock && (st_q.rate == DET_SD);

        if (force_byp_i) begin
            st_d.lock = 1'b0;
            st_d.cnt  = '0;
            st_d.rate = det_rate_i;
        end else if (!st_q.lock) begin
            // acquisition: run length of accepted, unchanged rate
            st_d.rate = det_rate_i;
            if (!accept) begin
                st_d.cnt = '0;
            end else if (same_rate) begin
                st_d.cnt = cnt_inc;
            end else begin
                st_d.cnt = ONE_L;
            end
            if (accept && (st_d.cnt == ACQ_L)) begin
                st_d.lock = 1'b1;
                st_d.cnt  = '0;
            end
        end else begin
            // tracking: run length of disagreement
            if (accept && same_rate) begin
                st_d.cnt = '0;
            end else begin
                st_d.cnt = cnt_inc;
            end
            if (st_d.cnt == LOS_L) begin
                st_d.lock = 1'b0;
                st_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lock: 1'b0, sd: 1'b0, rate: DET_NONE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign lock_o = st_q.lock;
    assign sd_o   = st_q.sd;

endmodule

// File: rtl/sdi_out_ctl.sv
module sdi_out_ctl
    import sdi_ctl_pkg::*;
(
    input  ctl_sync_t ctl_i,
    input  logic      lock_i,
    output logic      retime_bypass_o,
    output logic      out1_mute_o,
    output logic      out2_mute_o,
    output logic      out2_clk_sel_o
);

    typedef struct packed {
        logic bypass;
        logic mute1;
        logic mute2;
        logic clk_sel;
    } outc_t;

    outc_t oc_d;

    always_comb begin
        oc_d.bypass  = ctl_i.force_byp || !lock_i;
        oc_d.clk_sel = ctl_i.clk_mode;
        // mute has top priority on both outputs
        oc_d.mute1   = !ctl_i.mute_n;
        // a recovered clock is meaningless while bypassed
        oc_d.mute2   = !ctl_i.mute_n || (ctl_i.clk_mode && oc_d.bypass);
    end

    assign retime_bypass_o = oc_d.bypass;
    assign out1_mute_o     = oc_d.mute1;
    assign out2_mute_o     = oc_d.mute2;
    assign out2_clk_sel_o  = oc_d.clk_sel;

endmodule

// File: rtl/sdi_reclock_ctl.sv
module sdi_reclock_ctl
    import sdi_ctl_pkg::*;
#(
    parameter int ACQ_CYC = 270000,
    parameter int LOS_CYC = 13500
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] rate_sel_i,
    input  logic       force_bypass_i,
    input  logic       mute_n_i,
    input  logic       clk_out_sel_i,
    input  logic       pll_lock_i,
    input  logic [1:0] det_rate_i,
    output logic       lock_o,
    output logic       sd_o,
    output logic       retime_bypass_o,
    output logic       out1_mute_o,
    output logic       out2_mute_o,
    output logic       out2_clk_sel_o
);

    localparam int SW = $bits(ctl_sync_t);

    ctl_sync_t ctl_raw;
    ctl_sync_t ctl_syn;
    logic      lock_int;

    assign ctl_raw = '{mute_n: mute_n_i, force_byp: force_bypass_i,
                       clk_mode: clk_out_sel_i, rsel: rate_sel_i};

    sdi_sync2 #(
        .W       (SW),
        .RST_VAL (CTL_RST)
    ) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ctl_raw),
        .q_o   (ctl_syn)
    );

    sdi_lock_track #(
        .ACQ_CYC (ACQ_CYC),
        .LOS_CYC (LOS_CYC)
    ) i_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .rsel_i      (ctl_syn.rsel),
        .force_byp_i (ctl_syn.force_byp),
        .pll_lock_i  (pll_lock_i),
        .det_rate_i  (det_rate_i),
        .lock_o      (lock_int),
        .sd_o        (sd_o)
    );

    sdi_out_ctl i_outc (
        .ctl_i           (ctl_syn),
        .lock_i          (lock_int),
        .retime_bypass_o (retime_bypass_o),
        .out1_mute_o     (out1_mute_o),
        .out2_mute_o     (out2_mute_o),
        .out2_clk_sel_o  (out2_clk_sel_o)
    );

    assign lock_o = lock_int;

endmodule

// File: rtl/sdi_reclock_ctl_chk.sv
module sdi_reclock_ctl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] rate_sel_i,
    input logic       force_bypass_i,
    input logic       mute_n_i,
    input logic       clk_out_sel_i,
    input logic       pll_lock_i,
    input logic [1:0] det_rate_i,
    input logic       lock_o,
    input logic       sd_o,
    input logic       retime_bypass_o,
    input logic       out1_mute_o,
    input logic       out2_mute_o,
    input logic       out2_clk_sel_o
);

    // R4
    lock_rise_pll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> $past(pll_lock_i));

    // R6
    lock_rise_rate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_o) |-> ($past(det_rate_i) != 2'b00));

    // R7
    byp_no_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        force_bypass_i && $past(force_bypass_i) && $past(force_bypass_i, 2) |=> !lock_o);

    // R8
    unlock_bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |-> retime_bypass_o);

    // R9
    mute_both_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mute_n_i && $past(!mute_n_i) |=> out1_mute_o && out2_mute_o);

    // R10
    out2_mute_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out2_mute_o |-> out1_mute_o || (out2_clk_sel_o && retime_bypass_o));

    // R10
    data_mode_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out1_mute_o && !out2_clk_sel_o |-> !out2_mute_o);

    // R11
    sd_needs_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |=> !sd_o);

    // R11
    sd_rise_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sd_o) |-> $past(lock_o));

endmodule

bind sdi_reclock_ctl sdi_reclock_ctl_chk i_chk (.*);

// File: tb/test_sdi_reclock_ctl.sv
module test_sdi_reclock_ctl;

    localparam int ACQ = 6;
    localparam int LOS = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate_sel = 2'b00;
    logic       force_bypass = 1'b0;
    logic       mute_n = 1'b1;
    logic       clk_sel = 1'b0;
    logic       pll_lock = 1'b0;
    logic [1:0] det_rate = 2'b00;

    logic lock_o, sd_o, retime_bypass_o, out1_mute_o, out2_mute_o, out2_clk_sel_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    sdi_reclock_ctl #(
        .ACQ_CYC (ACQ),
        .LOS_CYC (LOS)
    ) i_sdi_reclock_ctl (
        .clk             (clk),
        .rst_n           (rst_n),
        .rate_sel_i      (rate_sel),
        .force_bypass_i  (force_bypass),
        .mute_n_i        (mute_n),
        .clk_out_sel_i   (clk_sel),
        .pll_lock_i      (pll_lock),
        .det_rate_i      (det_rate),
        .lock_o          (lock_o),
        .sd_o            (sd_o),
        .retime_bypass_o (retime_bypass_o),
        .out1_mute_o     (out1_mute_o),
        .out2_mute_o     (out2_mute_o),
        .out2_clk_sel_o  (out2_clk_sel_o)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    // ---------------- behavioural reference model ----------------
    // synchronized controls packed as {mute_n, bypass, clk_mode, rsel[1:0]}
    bit [4:0] syq[$];
    bit [4:0] sy_s;
    int       run_len;
    int       miss_len;
    bit       m_lock;
    bit       m_sd;
    bit [1:0] m_rate;

    function automatic bit accepted(bit [1:0] sel, bit [1:0] det, bit pl);
        if (!pl || det == 2'b00) return 1'b0;
        if (sel == 2'b01) return det == 2'b01;
        if (sel == 2'b10) return det >= 2'b10;
        return 1'b1;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            syq = {5'b10000};
            sy_s = 5'b10000;
            run_len = 0;
            miss_len = 0;
            m_lock = 1'b0;
            m_sd = 1'b0;
            m_rate = 2'b00;
        end else begin
            bit acc;
            acc = accepted(sy_s[1:0], det_rate, pll_lock);
            m_sd = m_lock && (m_rate == 2'b01);
            if (sy_s[3]) begin
                m_lock = 1'b0;
                run_len = 0;
                miss_len = 0;
                m_rate = det_rate;
            end else if (!m_lock) begin
                if (!acc) run_len = 0;
                else if (det_rate == m_rate) run_len++;
                else run_len = 1;
                m_rate = det_rate;
                if (run_len == ACQ) begin
                    m_lock = 1'b1;
                    run_len = 0;
                    miss_len = 0;
                end
            end else begin
                if (acc && det_rate == m_rate) miss_len = 0;
                else miss_len++;
                if (miss_len == LOS) begin
                    m_lock = 1'b0;
                    miss_len = 0;
                    run_len = 0;
                end
            end
            syq.push_back({mute_n, force_bypass, clk_sel, rate_sel});
            sy_s = syq.pop_front();
        end
    end

    // compare every clock, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit e_byp;
            e_byp = sy_s[3] || !m_lock;
            chk("R4", "model lock_o", lock_o, m_lock);
            chk("R11", "model sd_o", sd_o, m_sd);
            chk("R8", "model retime_bypass_o", retime_bypass_o, e_byp);
            chk("R9", "model out1_mute_o", out1_mute_o, !sy_s[4]);
            chk("R10", "model out2_mute_o", out2_mute_o, !sy_s[4] || (sy_s[2] && e_byp));
            chk("R2", "model out2_clk_sel_o", out2_clk_sel_o, sy_s[2]);
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(4 * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        done = 1'b1;
        finish_run();
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1", "lock_o", lock_o, 1'b0);
        chk("R1", "sd_o", sd_o, 1'b0);
        chk("R1", "retime_bypass_o", retime_bypass_o, 1'b1);
        chk("R1", "out1_mute_o", out1_mute_o, 1'b0);
        chk("R1", "out2_mute_o", out2_mute_o, 1'b0);
        chk("R1", "out2_clk_sel_o", out2_clk_sel_o, 1'b0);
        rst_n = 1'b1;
        step(2);

        // R4 acquisition in automatic mode on SD
        pll_lock = 1'b1;
        det_rate = 2'b01;
        step(5);
        chk("R4", "lock before window", lock_o, 1'b0);
        step(1);
        chk("R4", "lock at window", lock_o, 1'b1);
        chk("R11", "sd same edge as lock", sd_o, 1'b0);
        step(1);
        chk("R11", "sd one edge after lock", sd_o, 1'b1);
        chk("R8", "retimer active when locked", retime_bypass_o, 1'b0);

        // R5 short loss ignored, full loss drops lock
        pll_lock = 1'b0;
        step(2);
        chk("R5", "short loss keeps lock", lock_o, 1'b1);
        pll_lock = 1'b1;
        step(1);
        chk("R5", "lock after recovery", lock_o, 1'b1);
        pll_lock = 1'b0;
        step(2);
        chk("R5", "lock before loss window", lock_o, 1'b1);
        step(1);
        chk("R5", "lock lost at window", lock_o, 1'b0);
        step(1);
        chk("R11", "sd low after unlock", sd_o, 1'b0);
        chk("R8", "bypass when unlocked", retime_bypass_o, 1'b1);

        // R5 rate change while locked
        pll_lock = 1'b1;
        det_rate = 2'b01;
        step(10);
        chk("R4", "relock SD", lock_o, 1'b1);
        det_rate = 2'b10;
        step(3);
        chk("R5", "rate change drops lock", lock_o, 1'b0);
        step(6);
        chk("R4", "lock on new HD rate", lock_o, 1'b1);
        step(2);
        chk("R11", "sd low for HD", sd_o, 1'b0);

        // R3 SD-only mode rejects HD and 3G
        rate_sel = 2'b01;
        step(30);
        chk("R3", "SD mode rejects HD", lock_o, 1'b0);
        det_rate = 2'b11;
        step(20);
        chk("R3", "SD mode rejects 3G", lock_o, 1'b0);
        det_rate = 2'b01;
        step(12);
        chk("R3", "SD mode accepts SD", lock_o, 1'b1);
        chk("R11", "sd high in SD mode", sd_o, 1'b1);

        // R3 HD mode rejects SD, accepts 3G
        rate_sel = 2'b10;
        step(20);
        chk("R3", "HD mode rejects SD", lock_o, 1'b0);
        det_rate = 2'b11;
        step(12);
        chk("R3", "HD mode accepts 3G", lock_o, 1'b1);
        chk("R11", "sd low for 3G", sd_o, 1'b0);

        // R3 code 11 behaves as automatic
        rate_sel = 2'b11;
        det_rate = 2'b01;
        step(14);
        chk("R3", "test code accepts SD", lock_o, 1'b1);

        // R6 unsupported rate never locks
        rate_sel = 2'b00;
        det_rate = 2'b00;
        step(20);
        chk("R6", "no lock on unsupported rate", lock_o, 1'b0);
        chk("R6", "bypass on unsupported rate", retime_bypass_o, 1'b1);

        // R7 R8 R10 forced bypass meets lock in clock mode
        det_rate = 2'b01;
        step(12);
        chk("R7", "locked before bypass", lock_o, 1'b1);
        clk_sel = 1'b1;
        step(3);
        chk("R2", "clock mode selected", out2_clk_sel_o, 1'b1);
        chk("R10", "clock output live when locked", out2_mute_o, 1'b0);
        force_bypass = 1'b1;
        step(2);
        chk("R8", "forced bypass", retime_bypass_o, 1'b1);
        chk("R10", "clock output muted in bypass", out2_mute_o, 1'b1);
        chk("R10", "primary output live in bypass", out1_mute_o, 1'b0);
        step(1);
        chk("R7", "lock cleared by bypass", lock_o, 1'b0);
        step(10);
        chk("R7", "lock held low in bypass", lock_o, 1'b0);
        clk_sel = 1'b0;
        step(3);
        chk("R10", "data output live in bypass", out2_mute_o, 1'b0);
        force_bypass = 1'b0;
        step(7);
        chk("R7", "no lock before full window", lock_o, 1'b0);
        step(1);
        chk("R7", "relock after release", lock_o, 1'b1);

        // R9 mute overrides bypass and lock
        force_bypass = 1'b1;
        clk_sel = 1'b1;
        mute_n = 1'b0;
        step(3);
        chk("R9", "out1 muted with bypass", out1_mute_o, 1'b1);
        chk("R9", "out2 muted with bypass", out2_mute_o, 1'b1);
        force_bypass = 1'b0;
        step(12);
        chk("R9", "locked while muted", lock_o, 1'b1);
        chk("R9", "out1 muted while locked", out1_mute_o, 1'b1);
        chk("R9", "out2 muted while locked", out2_mute_o, 1'b1);
        mute_n = 1'b1;
        step(1);
        chk("R2", "mute release after one edge", out1_mute_o, 1'b1);
        step(1);
        chk("R2", "mute release after two edges", out1_mute_o, 1'b0);

        // R2 select latency
        clk_sel = 1'b0;
        step(1);
        chk("R2", "select after one edge", out2_clk_sel_o, 1'b1);
        step(1);
        chk("R2", "select after two edges", out2_clk_sel_o, 1'b0);

        step(2);
        done = 1'b1;
        finish_run();
    end

endmodule